// File: doc/BRIEF.md
# Integer Execute Stage with Immediate Handling

This block is the execute step of a 32-bit load-store integer core. It receives an already decoded instruction: the 6-bit major opcode, the 6-bit function code used when the opcode is the register-register group, a 5-bit constant shift count, the two source register values and the 16-bit immediate field. For each accepted instruction it produces four things. The first is the 32-bit result with a register write-enable. The second is a signed overflow flag. The third is the effective memory address, the first source plus the sign-extended immediate. The fourth is a misalignment flag for word-sized memory accesses.

Each opcode chooses its own immediate extension. Arithmetic and compare immediates are sign-extended. Logical immediates are zero-extended. The non-trapping add immediate sign-extends like the trapping one and differs only in that it never reports overflow. When overflow is reported, the write-enable drops so that the destination register keeps its old value.

Instructions enter through a valid/ready handshake and leave through a one-entry output register with its own valid/ready pair. An instruction is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output slot is empty or the consumer takes the slot on the same edge. While `out_valid` is high and `out_ready` is low, every output is held.

Top module: `exec_stage`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: An instruction accepted on an edge shows up with `out_valid` = 1 after that edge. While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and all outputs stay unchanged. A slot that is consumed can be refilled on the same edge.
- R3: Trapping add immediate (opcode 0x08), register add (opcode 0x00, function 0x20) and register subtract (function 0x22) give the wrapped 32-bit result and raise overflow on signed overflow. When overflow is raised, write-enable is 0.
- R4: Non-trapping add immediate (opcode 0x09) adds the sign-extended immediate, and non-trapping subtract (function 0x23) subtracts. Neither ever raises overflow, and both always write.
- R5: AND/OR/XOR immediate (opcodes 0x0C/0x0D/0x0E) zero-extend the immediate. Register AND/OR/XOR/NOR use functions 0x24/0x25/0x26/0x27.
- R6: Upper-immediate load (opcode 0x0F) returns the immediate in bits 31:16, with bits 15:0 cleared.
- R7: Signed less-than (function 0x2A, immediate opcode 0x0A) and unsigned less-than (function 0x2B, immediate opcode 0x0B) return 1 or 0. Both immediate forms sign-extend, and the unsigned forms then compare both operands as unsigned.
- R8: Shifts act on the second source. Constant-count shifts use the shift-count input: left 0x00, logical right 0x02, arithmetic right 0x03. Variable shifts use bits 4:0 of the first source: left 0x04, logical right 0x06, arithmetic right 0x07. Arithmetic right fills with the sign bit.
- R9: `out_addr` is the first source plus the sign-extended immediate. Word load (0x23) and word store (0x2B) raise misalignment when address bits 1:0 are not 00. Byte load (0x20) and byte store (0x28) never do. Memory opcodes have write-enable 0 and result 0.
- R10: Any opcode or function code not listed above gives result 0, write-enable 0 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Stage can take an instruction this edge |
| in_opcode | input | 6 | Major opcode |
| in_funct | input | 6 | Function code for the register-register group |
| in_shamt | input | 5 | Constant shift count |
| in_src_a | input | 32 | First source register value |
| in_src_b | input | 32 | Second source register value |
| in_imm | input | 16 | Immediate field |
| out_valid | output | 1 | Result slot holds an instruction |
| out_ready | input | 1 | Consumer takes the slot this edge |
| out_result | output | 32 | Computed value |
| out_wr_en | output | 1 | Destination register should be written |
| out_overflow | output | 1 | Signed overflow on a trapping operation |
| out_addr | output | 32 | Effective memory address |
| out_misalign | output | 1 | Word access not on a 4-byte boundary |

## Verification
All results of an instruction are due in the cycle after the rising edge that accepts it, because one register sits between the inputs and the outputs. The bench changes inputs on falling edges and reads the outputs on the falling edge that follows the capture edge, so each comparison falls in the middle of the cycle where the value must be present. For back-pressure, the bench samples again one and two falling edges later. It expects the first instruction to stay unchanged with `in_ready` low, and the queued instruction to appear only after the edge where `out_ready` returns high.

// File: rtl/exec_pkg.sv
package exec_pkg;
  // major opcodes
  localparam logic [5:0] OPC_REG           = 6'h00;
  localparam logic [5:0] OPC_ADD_IMM       = 6'h08;
  localparam logic [5:0] OPC_ADD_IMM_NOTRP = 6'h09;
  localparam logic [5:0] OPC_LESS_IMM      = 6'h0A;
  localparam logic [5:0] OPC_LESS_IMM_U    = 6'h0B;
  localparam logic [5:0] OPC_AND_IMM       = 6'h0C;
  localparam logic [5:0] OPC_OR_IMM        = 6'h0D;
  localparam logic [5:0] OPC_XOR_IMM       = 6'h0E;
  localparam logic [5:0] OPC_UPPER_IMM     = 6'h0F;
  localparam logic [5:0] OPC_LOAD_BYTE     = 6'h20;
  localparam logic [5:0] OPC_LOAD_WORD     = 6'h23;
  localparam logic [5:0] OPC_STORE_BYTE    = 6'h28;
  localparam logic [5:0] OPC_STORE_WORD    = 6'h2B;

  // register-group function codes
  localparam logic [5:0] FN_SHL_K    = 6'h00;
  localparam logic [5:0] FN_SHR_K    = 6'h02;
  localparam logic [5:0] FN_SAR_K    = 6'h03;
  localparam logic [5:0] FN_SHL_V    = 6'h04;
  localparam logic [5:0] FN_SHR_V    = 6'h06;
  localparam logic [5:0] FN_SAR_V    = 6'h07;
  localparam logic [5:0] FN_ADD      = 6'h20;
  localparam logic [5:0] FN_SUB      = 6'h22;
  localparam logic [5:0] FN_SUB_NOTR = 6'h23;
  localparam logic [5:0] FN_AND      = 6'h24;
  localparam logic [5:0] FN_OR       = 6'h25;
  localparam logic [5:0] FN_XOR      = 6'h26;
  localparam logic [5:0] FN_NOR      = 6'h27;
  localparam logic [5:0] FN_LESS     = 6'h2A;
  localparam logic [5:0] FN_LESS_U   = 6'h2B;

  // how an opcode widens its immediate
  typedef enum logic [1:0] {
    EXT_SIGN  = 2'd0,
    EXT_ZERO  = 2'd1,
    EXT_UPPER = 2'd2
  } ext_mode_e;
endpackage

// File: rtl/exec_imm_ext.sv
module exec_imm_ext
  import exec_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [5:0]       opcode,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  sext_imm,
  output logic [XLEN-1:0]  op_imm
);
  localparam int PAD = XLEN - IMM_W;

  ext_mode_e mode;

  always_comb begin
    unique case (opcode)
      OPC_AND_IMM, OPC_OR_IMM, OPC_XOR_IMM: mode = EXT_ZERO;
      OPC_UPPER_IMM:                        mode = EXT_UPPER;
      default:                              mode = EXT_SIGN;
    endcase
  end

  assign sext_imm = {{PAD{imm[IMM_W-1]}}, imm};

  always_comb begin
    unique case (mode)
      EXT_ZERO:  op_imm = {{PAD{1'b0}}, imm};
      EXT_UPPER: op_imm = {imm, {PAD{1'b0}}};
      default:   op_imm = sext_imm;
    endcase
  end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int SHW  = 5
) (
  input  logic [5:0]      opcode,
  input  logic [5:0]      funct,
  input  logic [SHW-1:0]  shamt,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [XLEN-1:0] op_imm,
  output logic [XLEN-1:0] result,
  output logic            wr_en,
  output logic            overflow
);
  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] operand_b;
  logic [XLEN-1:0] sum, diff;
  logic            sum_ovf, diff_ovf;
  logic [SHW-1:0]  var_amt;
  logic            known;
  logic            trap_add, trap_sub;

  assign operand_b = (opcode == OPC_REG) ? src_b : op_imm;
  assign sum       = src_a + operand_b;
  assign diff      = src_a - operand_b;
  assign sum_ovf   = (src_a[MSB] == operand_b[MSB]) && (sum[MSB] != src_a[MSB]);
  assign diff_ovf  = (src_a[MSB] != operand_b[MSB]) && (diff[MSB] != src_a[MSB]);
  assign var_amt   = src_a[SHW-1:0];

  always_comb begin
    result   = '0;
    known    = 1'b1;
    trap_add = 1'b0;
    trap_sub = 1'b0;
    unique case (opcode)
      OPC_REG: begin
        unique case (funct)
          FN_SHL_K:    result = src_b << shamt;
          FN_SHR_K:    result = src_b >> shamt;
          FN_SAR_K:    result = $signed(src_b) >>> shamt;
          FN_SHL_V:    result = src_b << var_amt;
          FN_SHR_V:    result = src_b >> var_amt;
          FN_SAR_V:    result = $signed(src_b) >>> var_amt;
          FN_ADD:      begin result = sum;  trap_add = 1'b1; end
          FN_SUB:      begin result = diff; trap_sub = 1'b1; end
          FN_SUB_NOTR: result = diff;
          FN_AND:      result = src_a & src_b;
          FN_OR:       result = src_a | src_b;
          FN_XOR:      result = src_a ^ src_b;
          FN_NOR:      result = ~(src_a | src_b);
          FN_LESS:     result = {{(XLEN-1){1'b0}}, $signed(src_a) < $signed(src_b)};
          FN_LESS_U:   result = {{(XLEN-1){1'b0}}, src_a < src_b};
          default:     known = 1'b0;
        endcase
      end
      OPC_ADD_IMM:       begin result = sum; trap_add = 1'b1; end
      OPC_ADD_IMM_NOTRP: result = sum;
      OPC_LESS_IMM:      result = {{(XLEN-1){1'b0}}, $signed(src_a) < $signed(operand_b)};
      OPC_LESS_IMM_U:    result = {{(XLEN-1){1'b0}}, src_a < operand_b};
      OPC_AND_IMM:       result = src_a & operand_b;
      OPC_OR_IMM:        result = src_a | operand_b;
      OPC_XOR_IMM:       result = src_a ^ operand_b;
      OPC_UPPER_IMM:     result = operand_b;
      default:           known = 1'b0;
    endcase
  end

  assign overflow = (trap_add && sum_ovf) || (trap_sub && diff_ovf);
  assign wr_en    = known && !overflow;
endmodule

// File: rtl/exec_agu.sv
module exec_agu
  import exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [5:0]      opcode,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] sext_imm,
  output logic [XLEN-1:0] addr,
  output logic            misalign
);
  localparam int ALIGN_BITS = $clog2(XLEN / 8);

  logic word_access;

  assign addr        = src_a + sext_imm;
  assign word_access = (opcode == OPC_LOAD_WORD) || (opcode == OPC_STORE_WORD);

  generate
    if (ALIGN_BITS > 0) begin : g_align
      assign misalign = word_access && (|addr[ALIGN_BITS-1:0]);
    end else begin : g_no_align
      assign misalign = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/exec_stage.sv
module exec_stage
  import exec_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int SHW   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [5:0]       in_opcode,
  input  logic [5:0]       in_funct,
  input  logic [SHW-1:0]   in_shamt,
  input  logic [XLEN-1:0]  in_src_a,
  input  logic [XLEN-1:0]  in_src_b,
  input  logic [IMM_W-1:0] in_imm,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_result,
  output logic             out_wr_en,
  output logic             out_overflow,
  output logic [XLEN-1:0]  out_addr,
  output logic             out_misalign
);
  logic [XLEN-1:0] sext_imm, op_imm;
  logic [XLEN-1:0] alu_result, agu_addr;
  logic            alu_wr_en, alu_ovf, agu_misalign;
  logic            is_mem;
  logic            take;

  exec_imm_ext #(.XLEN(XLEN), .IMM_W(IMM_W)) u_ext (
    .opcode  (in_opcode),
    .imm     (in_imm),
    .sext_imm(sext_imm),
    .op_imm  (op_imm)
  );

  exec_alu #(.XLEN(XLEN), .SHW(SHW)) u_alu (
    .opcode  (in_opcode),
    .funct   (in_funct),
    .shamt   (in_shamt),
    .src_a   (in_src_a),
    .src_b   (in_src_b),
    .op_imm  (op_imm),
    .result  (alu_result),
    .wr_en   (alu_wr_en),
    .overflow(alu_ovf)
  );

  exec_agu #(.XLEN(XLEN)) u_agu (
    .opcode  (in_opcode),
    .src_a   (in_src_a),
    .sext_imm(sext_imm),
    .addr    (agu_addr),
    .misalign(agu_misalign)
  );

  assign is_mem   = (in_opcode == OPC_LOAD_BYTE) || (in_opcode == OPC_LOAD_WORD) ||
                    (in_opcode == OPC_STORE_BYTE) || (in_opcode == OPC_STORE_WORD);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_result   <= '0;
      out_wr_en    <= 1'b0;
      out_overflow <= 1'b0;
      out_addr     <= '0;
      out_misalign <= 1'b0;
    end else if (take) begin
      out_result   <= is_mem ? '0 : alu_result;
      out_wr_en    <= alu_wr_en && !is_mem;
      out_overflow <= alu_ovf;
      out_addr     <= agu_addr;
      out_misalign <= agu_misalign;
    end
  end
endmodule

// File: rtl/exec_stage_chk.sv
module exec_stage_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_result,
  input logic            out_wr_en,
  input logic            out_overflow,
  input logic [XLEN-1:0] out_addr,
  input logic            out_misalign
);
  // R3: overflow suppresses the register write
  p_no_write_on_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow) |-> !out_wr_en);

  // R2: a stalled slot blocks new input
  p_stall_blocks_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R2: a stalled slot keeps all of its fields
  p_stall_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_wr_en)
      && $stable(out_overflow) && $stable(out_addr) && $stable(out_misalign)));

  // R2: an accepted instruction fills the slot
  p_accept_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9: misalignment only for a non-zero low address pair
  p_misalign_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_misalign) |-> (out_addr[1:0] != 2'b00));
endmodule

bind exec_stage exec_stage_chk #(.XLEN(XLEN)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_wr_en   (out_wr_en),
  .out_overflow(out_overflow),
  .out_addr    (out_addr),
  .out_misalign(out_misalign)
);

// File: tb/test_exec_stage.sv
`timescale 1ns/1ps
module test_exec_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_opcode = '0;
  logic [5:0]  in_funct = '0;
  logic [4:0]  in_shamt = '0;
  logic [31:0] in_src_a = '0;
  logic [31:0] in_src_b = '0;
  logic [15:0] in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_wr_en;
  logic        out_overflow;
  logic [31:0] out_addr;
  logic        out_misalign;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  exec_stage i_exec_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_funct(in_funct), .in_shamt(in_shamt),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_overflow(out_overflow), .out_addr(out_addr),
    .out_misalign(out_misalign)
  );

  typedef struct packed {
    logic [31:0] res;
    logic        wr;
    logic        ovf;
    logic [31:0] addr;
    logic        mis;
  } exp_t;

  function automatic exp_t model(logic [5:0] op, logic [5:0] fn, logic [4:0] sh,
                                 logic [31:0] a, logic [31:0] b, logic [15:0] imm);
    exp_t e;
    logic [31:0] se, ze, s, d;
    bit known;
    se = {{16{imm[15]}}, imm};
    ze = {16'h0, imm};
    e = '0;
    known = 1;
    e.addr = a + se;
    case (op)
      6'h00: case (fn)
        6'h00: e.res = b << sh;
        6'h02: e.res = b >> sh;
        6'h03: e.res = $signed(b) >>> sh;
        6'h04: e.res = b << a[4:0];
        6'h06: e.res = b >> a[4:0];
        6'h07: e.res = $signed(b) >>> a[4:0];
        6'h20: begin s = a + b; e.res = s; e.ovf = (a[31] == b[31]) && (s[31] != a[31]); end
        6'h22: begin d = a - b; e.res = d; e.ovf = (a[31] != b[31]) && (d[31] != a[31]); end
        6'h23: e.res = a - b;
        6'h24: e.res = a & b;
        6'h25: e.res = a | b;
        6'h26: e.res = a ^ b;
        6'h27: e.res = ~(a | b);
        6'h2A: e.res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        6'h2B: e.res = (a < b) ? 32'd1 : 32'd0;
        default: known = 0;
      endcase
      6'h08: begin s = a + se; e.res = s; e.ovf = (a[31] == se[31]) && (s[31] != a[31]); end
      6'h09: e.res = a + se;
      6'h0A: e.res = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
      6'h0B: e.res = (a < se) ? 32'd1 : 32'd0;
      6'h0C: e.res = a & ze;
      6'h0D: e.res = a | ze;
      6'h0E: e.res = a ^ ze;
      6'h0F: e.res = {imm, 16'h0};
      6'h20, 6'h28: known = 0;
      6'h23, 6'h2B: begin known = 0; e.mis = (e.addr[1:0] != 2'b00); end
      default: known = 0;
    endcase
    e.wr = known && !e.ovf;
    return e;
  endfunction

  function automatic string tag_of(logic [5:0] op, logic [5:0] fn);
    case (op)
      6'h00: case (fn)
        6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07: return "R8";
        6'h20, 6'h22: return "R3";
        6'h23: return "R4";
        6'h24, 6'h25, 6'h26, 6'h27: return "R5";
        6'h2A, 6'h2B: return "R7";
        default: return "R10";
      endcase
      6'h08: return "R3";
      6'h09: return "R4";
      6'h0A, 6'h0B: return "R7";
      6'h0C, 6'h0D, 6'h0E: return "R5";
      6'h0F: return "R6";
      6'h20, 6'h23, 6'h28, 6'h2B: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(exp_t e, string tag);
    check(out_valid === 1'b1, tag, "out_valid", {31'h0, out_valid}, 32'h1);
    check(out_result === e.res, tag, "result", out_result, e.res);
    check(out_wr_en === e.wr, tag, "wr_en", {31'h0, out_wr_en}, {31'h0, e.wr});
    check(out_overflow === e.ovf, tag, "overflow", {31'h0, out_overflow}, {31'h0, e.ovf});
    check(out_addr === e.addr, tag, "addr", out_addr, e.addr);
    check(out_misalign === e.mis, tag, "misalign", {31'h0, out_misalign}, {31'h0, e.mis});
  endtask

  task automatic drive(logic [5:0] op, logic [5:0] fn, logic [4:0] sh,
                       logic [31:0] a, logic [31:0] b, logic [15:0] imm);
    in_opcode = op; in_funct = fn; in_shamt = sh;
    in_src_a = a; in_src_b = b; in_imm = imm;
  endtask

  task automatic run_op(logic [5:0] op, logic [5:0] fn, logic [4:0] sh,
                        logic [31:0] a, logic [31:0] b, logic [15:0] imm);
    @(negedge clk);
    drive(op, fn, sh, a, b, imm);
    in_valid = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    compare(model(op, fn, sh, a, b, imm), tag_of(op, fn));
  endtask

  localparam logic [5:0] OPS [20] = '{6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h08, 6'h09,
    6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E, 6'h0F, 6'h20, 6'h23, 6'h28, 6'h2B, 6'h3F, 6'h01, 6'h11};
  localparam logic [5:0] FNS [16] = '{6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07, 6'h20,
    6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27, 6'h2A, 6'h2B, 6'h21};

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 5))
      0: return 32'h7FFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t e1, e2;
    void'($urandom(32'd20250917));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid === 1'b0, "R1", "out_valid in reset", {31'h0, out_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1", "out_valid after reset", {31'h0, out_valid}, 32'h0);
    check(in_ready === 1'b1, "R1", "in_ready after reset", {31'h0, in_ready}, 32'h1);

    // directed corners
    run_op(6'h08, 6'h00, 5'd0, 32'h7FFF_FFFF, 32'h0, 16'h0001);   // R3 overflow
    run_op(6'h00, 6'h22, 5'd0, 32'h8000_0000, 32'h1, 16'h0);      // R3 sub overflow
    run_op(6'h09, 6'h00, 5'd0, 32'h7FFF_FFFF, 32'h0, 16'h0001);   // R4 no trap
    run_op(6'h09, 6'h00, 5'd0, 32'h0000_0010, 32'h0, 16'hFFFD);   // R4 sign extension
    run_op(6'h0C, 6'h00, 5'd0, 32'hFFFF_FFFF, 32'h0, 16'h8723);   // R5 zero extension
    run_op(6'h0D, 6'h00, 5'd0, 32'h5678_0000, 32'h0, 16'hABCD);   // R5
    run_op(6'h0F, 6'h00, 5'd0, 32'h1234_5678, 32'h0, 16'h5678);   // R6
    run_op(6'h0B, 6'h00, 5'd0, 32'h0000_0005, 32'h0, 16'hFFFF);   // R7 unsigned -> 1
    run_op(6'h0A, 6'h00, 5'd0, 32'h0000_0005, 32'h0, 16'hFFFF);   // R7 signed -> 0
    run_op(6'h00, 6'h03, 5'd4, 32'h0, 32'h8000_0000, 16'h0);      // R8 arithmetic
    run_op(6'h00, 6'h07, 5'd0, 32'h0000_0024, 32'h8000_0000, 16'h0); // R8 low 5 bits only
    run_op(6'h23, 6'h00, 5'd0, 32'h0000_1000, 32'h0, 16'h0002);   // R9 misaligned word
    run_op(6'h2B, 6'h00, 5'd0, 32'h0000_1008, 32'h0, 16'hFFFC);   // R9 aligned word
    run_op(6'h20, 6'h00, 5'd0, 32'h0000_1000, 32'h0, 16'h0003);   // R9 byte no flag
    run_op(6'h3F, 6'h00, 5'd0, 32'h1, 32'h2, 16'h3);              // R10 unknown opcode
    run_op(6'h00, 6'h21, 5'd0, 32'h1, 32'h2, 16'h3);              // R10 unknown function

    // R2: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    drive(6'h0E, 6'h00, 5'd0, 32'h0000_FF00, 32'h0, 16'h0FF0);
    e1 = model(6'h0E, 6'h00, 5'd0, 32'h0000_FF00, 32'h0, 16'h0FF0);
    in_valid = 1'b1;
    @(negedge clk);
    compare(e1, "R2");
    check(in_ready === 1'b0, "R2", "in_ready while stalled", {31'h0, in_ready}, 32'h0);
    drive(6'h00, 6'h27, 5'd0, 32'h0F0F_0000, 32'h0000_00F0, 16'h0);
    e2 = model(6'h00, 6'h27, 5'd0, 32'h0F0F_0000, 32'h0000_00F0, 16'h0);
    @(negedge clk);
    compare(e1, "R2");
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    compare(e2, "R2");
    @(negedge clk);
    check(out_valid === 1'b0, "R2", "slot drained", {31'h0, out_valid}, 32'h0);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [5:0] op, fn;
      op = OPS[$urandom_range(0, 19)];
      fn = FNS[$urandom_range(0, 15)];
      run_op(op, fn, 5'($urandom), pick_val(), pick_val(), 16'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule